// File: doc/BRIEF.md
# Display Register Read Engine (4-wire SPI, separate D/C line)

This block performs one register read from a small display controller over an 8-bit SPI link whose command/data selection travels on its own line. A host pulses `start` with a command code and the number of bytes it wants. The engine checks the code against a fixed set of readable codes, then lowers chip select and D/C, shifts the command out MSB first, keeps shifting with MOSI held low while it captures the reply, and hands each reply byte out on a one-cycle `rd_valid` strobe. `done` marks the final byte.

Two codes, identification (0x04) and status (0x09), answer after one idle clock. For them the engine clocks one extra byte and moves the whole reply up by one bit, so the host sees properly aligned bytes. The serial clock runs at a reduced rate, derived from parameters: the lower of the read ceiling and half the link maximum. Rejected requests raise `err` and leave the bus idle.

Top module: `panel_reg_reader`

## Requirements
- R1: Only codes 0x04, 0x09, 0x0A, 0x0B, 0x0C, 0x0D, 0x0E, 0x0F, 0x2E, 0x3E, 0x45, 0x52, 0x54, 0x56, 0x5F, 0xA1 and 0xA8 start a read. Any other code, and any request with length 0, gives a one-cycle `err` pulse one cycle after `start`. Chip select stays high and SCLK stays low.
- R2: For codes 0x04 and 0x09 only lengths 3 and 4 are accepted. Any other length is rejected as in R1.
- R3: `dc` is low exactly while `cs_n` is low. `cs_n` stays low without a break from before the first command bit until the last reply bit. When idle, `cs_n`=1, `dc`=1 and `sclk`=0.
- R4: The command goes out MSB first, so that rising SCLK edge k (k=1..8) sees command bit 8-k on `mosi`. From rising edge 9 onward, `mosi` is 0.
- R5: Every SCLK level lasts HALF clock cycles, and so does the gap between the fall of `cs_n` and the first rising edge. HALF = ceil(SYS_HZ / (2*F)), where F = min(RD_MAX_HZ, LINK_MAX_HZ/2).
- R6: One transaction has 8*(1+N) rising SCLK edges. N = length for ordinary codes and length+1 for 0x04 and 0x09.
- R7: For ordinary codes, reply bits are sampled on rising SCLK edges, MSB first. Output byte i equals captured byte i.
- R8: For 0x04 and 0x09, output byte i = (captured byte i << 1) | bit 7 of captured byte i+1, for i = 0 .. length-1.
- R9: Exactly `length` `rd_valid` pulses are produced per accepted read. `done` is high only together with the last of them.
- R10: A `start` pulse while `busy` is high is ignored. It causes no error, and it changes neither the command in flight nor its reply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| cmd | input | 8 | Command code to read |
| len | input | LEN_W | Number of reply bytes wanted |
| busy | output | 1 | Transaction in progress |
| err | output | 1 | Request rejected (one-cycle pulse) |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select, low for the whole read |
| mosi | output | 1 | Serial data to the panel |
| miso | input | 1 | Serial data from the panel |
| rd_valid | output | 1 | Reply byte strobe |
| rd_data | output | 8 | Reply byte |
| done | output | 1 | Marks the last reply byte |

## Verification
`err` is due one cycle after the rejected `start`. The fall of `cs_n` comes one cycle after an accepted `start`. Each SCLK transition comes HALF cycles after the previous event. Each reply byte appears on `rd_valid` one cycle after the rising edge that completed it, and `cs_n` rises on the last falling SCLK edge.

The bench samples on the falling clock edge. A behavioural model follows each SCLK edge it sees, times it against HALF, and checks MOSI at each rising edge. Each reply byte is compared when `cs_n` rises, by which point all `rd_valid` strobes are due. Rejections are checked after two half-periods, with the requirement that no chip-select fall has been seen.

// File: rtl/panel_rd_pkg.sv
// Shared types and decode helpers for the display register read engine.
// Assumes 8-bit command codes and a fixed readable set.
package panel_rd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CMD  = 2'd1,
        PH_RESP = 2'd2
    } rd_phase_e;

    // True when the code belongs to the readable set.
    function automatic logic code_readable(input logic [7:0] c);
        case (c)
            8'h04, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0D, 8'h0E, 8'h0F,
            8'h2E, 8'h3E, 8'h45, 8'h52, 8'h54, 8'h56, 8'h5F,
            8'hA1, 8'hA8: return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction

    // True for the codes whose reply is preceded by one idle clock.
    function automatic logic code_skewed(input logic [7:0] c);
        return (c == 8'h04) || (c == 8'h09);
    endfunction

endpackage

// File: rtl/rd_rate_gen.sv
// Half-period tick generator for the read serial clock.
// Assumes HALF >= 2; the count restarts from zero whenever run is low.
module rd_rate_gen #(
    parameter int HALF = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF) + 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    // Count system cycles inside one SCLK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/rd_bit_engine.sv
// Serial shifter: drives chip select, D/C, SCLK and MOSI, and captures MISO.
// Mode 0 timing: data changes after the falling edge and is sampled on the
// rising edge. Assumes nbytes >= 1 when launch is pulsed while idle.
module rd_bit_engine
    import panel_rd_pkg::*;
#(
    parameter int NB_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            launch,
    input  logic [7:0]      cmd_in,
    input  logic [NB_W-1:0] nbytes,
    input  logic            tick,
    input  logic            miso,
    output logic            sclk,
    output logic            cs_n,
    output logic            dc,
    output logic            mosi,
    output logic            busy,
    output logic            byte_stb,
    output logic [7:0]      byte_val
);
    localparam int TB_W = NB_W + 4;

    rd_phase_e       phase;
    logic [TB_W-1:0] bitcnt;
    logic [TB_W-1:0] total_bits;
    logic [TB_W-1:0] bit_nxt;
    logic [7:0]      cmd_sr;
    logic [6:0]      rx_sr;

    assign busy    = (phase != PH_IDLE);
    assign bit_nxt = bitcnt + 1'b1;

    // Walk through the command bits, then the reply bits, one SCLK at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bitcnt     <= '0;
            total_bits <= '0;
            cmd_sr     <= '0;
            rx_sr      <= '0;
            sclk       <= 1'b0;
            cs_n       <= 1'b1;
            dc         <= 1'b1;
            mosi       <= 1'b0;
            byte_stb   <= 1'b0;
            byte_val   <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (phase == PH_IDLE) begin
                if (launch) begin
                    phase      <= PH_CMD;
                    bitcnt     <= '0;
                    total_bits <= {({1'b0, nbytes} + 1'b1), 3'b000};
                    cmd_sr     <= cmd_in;
                    mosi       <= cmd_in[7];
                    cs_n       <= 1'b0;
                    dc         <= 1'b0;
                end
            end else if (tick) begin
                if (!sclk) begin
                    sclk <= 1'b1;
                    if (phase == PH_RESP) begin
                        rx_sr <= {rx_sr[5:0], miso};
                        if (bitcnt[2:0] == 3'd7) begin
                            byte_stb <= 1'b1;
                            byte_val <= {rx_sr, miso};
                        end
                    end
                end else begin
                    sclk   <= 1'b0;
                    bitcnt <= bit_nxt;
                    if (bit_nxt == total_bits) begin
                        phase <= PH_IDLE;
                        cs_n  <= 1'b1;
                        dc    <= 1'b1;
                        mosi  <= 1'b0;
                    end else if (bit_nxt == TB_W'(8)) begin
                        phase <= PH_RESP;
                        mosi  <= 1'b0;
                    end else if (phase == PH_CMD) begin
                        mosi   <= cmd_sr[6];
                        cmd_sr <= {cmd_sr[6:0], 1'b0};
                    end
                end
            end
        end
    end

    // R4: the line to the panel stays quiet while the reply is clocked in.
    a_r4_mosi_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESP) |-> !mosi);
    // R3: D/C is low whenever the panel is selected.
    a_r3_dc_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !dc);
    // R3: no clock pulses while deselected.
    a_r3_idle_sclk_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

endmodule

// File: rtl/rd_realign.sv
// Output stage: passes reply bytes through, or for skewed codes rebuilds
// each byte from two neighbours. Assumes len_in >= 1 at launch.
module rd_realign #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    input  logic             skew_in,
    input  logic [LEN_W-1:0] len_in,
    input  logic             byte_stb,
    input  logic [7:0]       byte_val,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done
);
    localparam int NB_W = LEN_W + 1;

    logic             skew_q;
    logic [LEN_W-1:0] len_q;
    logic [NB_W-1:0]  idx;
    logic [7:0]       prev;

    // Latch the request shape and emit one aligned byte per captured byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            skew_q   <= 1'b0;
            len_q    <= '0;
            idx      <= '0;
            prev     <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            done     <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            if (launch) begin
                skew_q <= skew_in;
                len_q  <= len_in;
                idx    <= '0;
            end else if (byte_stb) begin
                idx  <= idx + 1'b1;
                prev <= byte_val;
                if (!skew_q) begin
                    rd_valid <= 1'b1;
                    rd_data  <= byte_val;
                    done     <= ((idx + 1'b1) == {1'b0, len_q});
                end else if (idx != '0) begin
                    rd_valid <= 1'b1;
                    rd_data  <= {prev[6:0], byte_val[7]};
                    done     <= (idx == {1'b0, len_q});
                end
            end
        end
    end

    // R9: the completion marker only rides on a delivered byte.
    a_r9_done_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_valid);

endmodule

// File: rtl/panel_reg_reader.sv
// Top: validates a read request, derives the reduced read clock and ties the
// shifter to the realignment stage. Assumes start is a one-cycle strobe.
module panel_reg_reader
    import panel_rd_pkg::*;
#(
    parameter int SYS_HZ      = 200_000_000,
    parameter int LINK_MAX_HZ = 10_000_000,
    parameter int RD_MAX_HZ   = 2_000_000,
    parameter int LEN_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       cmd,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             err,
    output logic             sclk,
    output logic             cs_n,
    output logic             dc,
    output logic             mosi,
    input  logic             miso,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             done
);
    localparam int NB_W   = LEN_W + 1;
    localparam int RD_HZ  = (LINK_MAX_HZ / 2 < RD_MAX_HZ) ? LINK_MAX_HZ / 2 : RD_MAX_HZ;
    localparam int HALF   = (SYS_HZ + 2 * RD_HZ - 1) / (2 * RD_HZ);
    localparam int AGE_W  = $clog2(HALF + 2) + 1;

    logic            skewed, len_ok, req_ok, launch, tick;
    logic            byte_stb;
    logic [7:0]      byte_val;
    logic [NB_W-1:0] nbytes;

    assign skewed = code_skewed(cmd);
    assign len_ok = skewed ? (len == LEN_W'(3) || len == LEN_W'(4)) : (len != '0);
    assign req_ok = code_readable(cmd) && len_ok;
    assign launch = start && !busy && req_ok;
    assign nbytes = skewed ? ({1'b0, len} + 1'b1) : {1'b0, len};

    // Flag a rejected request for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= start && !busy && !req_ok;
    end

    rd_rate_gen #(.HALF(HALF)) u_rate (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
    );

    rd_bit_engine #(.NB_W(NB_W)) u_bits (
        .clk(clk), .rst_n(rst_n), .launch(launch), .cmd_in(cmd),
        .nbytes(nbytes), .tick(tick), .miso(miso), .sclk(sclk),
        .cs_n(cs_n), .dc(dc), .mosi(mosi), .busy(busy),
        .byte_stb(byte_stb), .byte_val(byte_val)
    );

    rd_realign #(.LEN_W(LEN_W)) u_align (
        .clk(clk), .rst_n(rst_n), .launch(launch), .skew_in(skewed),
        .len_in(len), .byte_stb(byte_stb), .byte_val(byte_val),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
    );

    // Checker state: cycles since the last SCLK change or chip-select fall.
    logic             sclk_d, cs_n_d;
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_n_d <= 1'b1;
            age    <= '0;
        end else begin
            sclk_d <= sclk;
            cs_n_d <= cs_n;
            if ((sclk != sclk_d) || (cs_n_d && !cs_n)) age <= AGE_W'(1);
            else if (age != '1)                       age <= age + 1'b1;
        end
    end

    // R5: every SCLK level lasts HALF system cycles.
    a_r5_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != sclk_d) |-> (age == AGE_W'(HALF)));
    // R1: a rejection never touches the bus.
    a_r1_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !sclk));

endmodule

// File: tb/tb_panel_reg_reader.sv
module tb_panel_reg_reader;
    localparam int LEN_W = 4;
    localparam int EXP_HALF = 50; // 200 MHz / (2 * min(2 MHz, 10 MHz/2))

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] cmd = '0;
    logic [LEN_W-1:0] len = '0;
    logic miso = 1'b0;
    logic busy, err, sclk, cs_n, dc, mosi, rd_valid, done;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    panel_reg_reader #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .len(len),
        .busy(busy), .err(err), .sclk(sclk), .cs_n(cs_n), .dc(dc),
        .mosi(mosi), .miso(miso), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_cmd = '0;
    int exp_len = 0;
    int exp_n = 0;
    bit exp_skew = 0;
    logic [7:0] resp[$];
    logic [7:0] exp_out[$];
    logic [7:0] got[$];
    int rises = 0, falls = 0, cs_falls = 0, err_cnt = 0, done_cnt = 0;
    int cyc = 0, last_evt = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic stream_bit(input int k);
        int j;
        if (k < 8) return 1'b1;          // junk while the command goes out
        j = k - 8;
        if (j / 8 < resp.size()) return resp[j / 8][7 - (j % 8)];
        return 1'b0;
    endfunction

    // Reference model: panel side plus per-cycle protocol checks.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            check(dc === cs_n, "R3 dc vs cs_n", dc, cs_n);
            if (cs_n && sclk) check(0, "R3 sclk idle", sclk, 0);
            if (prev_cs && !cs_n) begin
                cs_falls++; rises = 0; falls = 0; last_evt = cyc;
                miso = stream_bit(0);
            end
            if (sclk !== prev_sclk) begin
                check(cyc - last_evt == EXP_HALF, "R5 half period", cyc - last_evt, EXP_HALF);
                last_evt = cyc;
                if (sclk) begin
                    rises++;
                    if (rises <= 8) check(mosi === exp_cmd[8 - rises], "R4 command bit", mosi, exp_cmd[8 - rises]);
                    else            check(mosi === 1'b0, "R4 mosi low in reply", mosi, 0);
                end else begin
                    falls++;
                    miso = stream_bit(falls);
                end
            end
            if (rd_valid) got.push_back(rd_data);
            if (done) begin
                done_cnt++;
                check(rd_valid && got.size() == exp_len, "R9 done on last byte", got.size(), exp_len);
            end
            if (err) err_cnt++;
            if (!prev_cs && cs_n) begin
                check(rises == 8 * (1 + exp_n), "R6 edge count", rises, 8 * (1 + exp_n));
                check(got.size() == exp_len, "R9 byte count", got.size(), exp_len);
                for (int i = 0; i < exp_len && i < got.size(); i++)
                    check(got[i] === exp_out[i], exp_skew ? "R8 realigned byte" : "R7 plain byte",
                          got[i], exp_out[i]);
            end
            prev_cs = cs_n;
            prev_sclk = sclk;
        end
    end

    task automatic do_read(input logic [7:0] c, input int l, input bit poke_busy);
        int e0;
        exp_cmd = c; exp_len = l;
        exp_skew = (c == 8'h04) || (c == 8'h09);
        exp_n = exp_skew ? l + 1 : l;
        resp.delete(); exp_out.delete(); got.delete();
        for (int i = 0; i < exp_n; i++) resp.push_back(8'h3C ^ 8'(i * 8'h57) ^ c ^ 8'(i << 5));
        for (int i = 0; i < l; i++)
            exp_out.push_back(exp_skew ? {resp[i][6:0], resp[i + 1][7]} : resp[i]);
        done_cnt = 0; e0 = err_cnt;
        @(negedge clk); start = 1'b1; cmd = c; len = LEN_W'(l);
        @(negedge clk); start = 1'b0;
        if (poke_busy) begin
            repeat (300) @(negedge clk);
            start = 1'b1; cmd = 8'h00; len = LEN_W'(3);   // R10: must be ignored
            @(negedge clk); start = 1'b0;
            cmd = 8'h04;
            repeat (2) @(negedge clk);
        end
        repeat (2 * EXP_HALF * 8 * (1 + exp_n) + 20) @(negedge clk);
        check(done_cnt == 1, "R9 single done", done_cnt, 1);
        check(err_cnt == e0, poke_busy ? "R10 no error while busy" : "R1 accepted", err_cnt - e0, 0);
        check(!busy && cs_n, "R3 idle after read", busy, 0);
    endtask

    task automatic do_reject(input logic [7:0] c, input int l, input string req);
        int e0, f0;
        e0 = err_cnt; f0 = cs_falls;
        @(negedge clk); start = 1'b1; cmd = c; len = LEN_W'(l);
        @(negedge clk); start = 1'b0;
        check(err === 1'b1, req, err, 1);
        repeat (2 * EXP_HALF) @(negedge clk);
        check(err_cnt == e0 + 1, req, err_cnt - e0, 1);
        check(cs_falls == f0 && cs_n && !sclk, req, cs_falls - f0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n && dc && !sclk && !busy && !err && !rd_valid && !done, "R3 reset state",
              {cs_n, dc, sclk, busy}, 4'b1100);
        do_read(8'h0A, 1, 0);          // R7 power mode, one byte
        do_read(8'h04, 3, 0);          // R8 identification
        do_read(8'h09, 4, 0);          // R8 status
        do_read(8'h2E, 2, 0);          // R7 memory read
        do_read(8'hA8, 5, 1);          // R7 plus R10 busy poke
        do_reject(8'h04, 2, "R2 id length 2");
        do_reject(8'h09, 5, "R2 status length 5");
        do_reject(8'h00, 1, "R1 code 00");
        do_reject(8'h3F, 1, "R1 code 3F");
        do_reject(8'h0A, 0, "R1 length 0");
        do_read(8'h45, 2, 0);          // R7 scanline
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule